// File: doc/BRIEF.md
# Edge-Thinning Non-Maximum Suppressor

This block takes a raster-ordered stream of gradient magnitudes, each tagged with a 2-bit quantized gradient direction, and thins edges down to one pixel width. Two full lines of magnitude are held in on-chip line memories, so a 3x3 neighbourhood is available around every pixel. Each pixel's magnitude is compared against the pair of neighbours that lies along its own gradient direction. The magnitude is passed on unchanged only when it beats both of them strictly. Otherwise it becomes zero.

The block sits between a gradient stage and a thresholding stage. Its output stream has the same raster order as its input and carries the frame-start and line-end markers. Output starts a fixed FRAME_W+2 clock cycles after input. The pixels of one frame must arrive on consecutive clock cycles. Frames may follow one another directly or be separated by idle cycles. Pixels on the outer ring of the frame are always reported as zero, because they lack a full neighbourhood.

Top module: `nms_thin`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, out_valid, out_sof and out_eol are 0 and out_mag is 0.
- R2: Every input cycle with in_valid high produces exactly one output cycle with out_valid high, FRAME_W+2 clock cycles later, and out_eol equals that pixel's in_eol.
- R3: The neighbour pair is picked by in_dir. Code 2'b00 compares left and right. Code 2'b01 compares upper-right and lower-left. Code 2'b10 compares above and below. Code 2'b11 compares upper-left and lower-right. "Above" is the previous line.
- R4: An interior pixel's output equals its input magnitude when that magnitude is strictly greater than both selected neighbours, and 0 otherwise. A tie with either neighbour gives 0.
- R5: Pixels in row 0, row FRAME_H-1, column 0 and column FRAME_W-1 of a frame are output as 0, whatever their magnitude and direction.
- R6: In any cycle with out_valid low, out_mag, out_sof and out_eol are all 0.
- R7: A pixel with in_sof high is taken as row 0, column 0. Its out_sof appears with the same latency as in R2. Consecutive frames, whether back to back or separated by idle cycles, are each processed from their own first pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Input pixel is first of a frame |
| in_eol | input | 1 | Input pixel is last of its line |
| in_mag | input | MAG_W | Gradient magnitude |
| in_dir | input | 2 | Quantized gradient direction code |
| out_valid | output | 1 | Output pixel present |
| out_sof | output | 1 | Output pixel is first of a frame |
| out_eol | output | 1 | Output pixel is last of its line |
| out_mag | output | MAG_W | Thinned magnitude |

## Verification
Low-range magnitudes create many ties. A design that compares with greater-or-equal would let plateaus through where zeros are due, and a flat frame would then come out non-zero inside. Frames with a single fixed direction code expose a swapped or mirrored neighbour pair, which would keep the wrong ridge pixels. Back-to-back frames and the outer ring are the other targets. A counter that ignores the frame-start flag, or a border test that is off by one, would zero or keep the wrong row or column. A slip of one cycle in the line memories would show up as a mismatch on every valid output.

// File: rtl/nms_pkg.sv
package nms_pkg;
  typedef enum logic [1:0] {
    DIR_H    = 2'b00,
    DIR_D45  = 2'b01,
    DIR_V    = 2'b10,
    DIR_D135 = 2'b11
  } grad_dir_e;
endpackage

// File: rtl/nms_line_delay.sv
// Fixed delay of DEPTH+1 cycles built on a RAM with a circular pointer.
module nms_line_delay #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    dout       <= mem[ptr_q];
    mem[ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= LAST);
endmodule

// File: rtl/nms_raster_pos.sv
// Tracks the raster position of the window centre and flags the outer ring.
module nms_raster_pos #(
  parameter int FRAME_W = 32,
  parameter int FRAME_H = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic sof,
  output logic border
);
  localparam int CW = $clog2(FRAME_W);
  localparam int RW = $clog2(FRAME_H);
  localparam logic [CW-1:0] LAST_C = CW'(FRAME_W - 1);
  localparam logic [RW-1:0] LAST_R = RW'(FRAME_H - 1);

  logic [CW-1:0] col_q, cur_col;
  logic [RW-1:0] row_q, cur_row;

  always_comb begin
    cur_col = sof ? '0 : col_q;
    cur_row = sof ? '0 : row_q;
    border  = (cur_row == '0) || (cur_row == LAST_R) ||
              (cur_col == '0) || (cur_col == LAST_C);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (valid) begin
      if (cur_col == LAST_C) begin
        col_q <= '0;
        row_q <= (cur_row == LAST_R) ? '0 : cur_row + 1'b1;
      end else begin
        col_q <= cur_col + 1'b1;
        row_q <= cur_row;
      end
    end
  end

  assert_pos_range_R7: assert property (@(posedge clk) disable iff (rst)
    (col_q <= LAST_C) && (row_q <= LAST_R));
endmodule

// File: rtl/nms_peak.sv
// Picks the neighbour pair for the direction code and tests for a strict peak.
module nms_peak import nms_pkg::*; #(
  parameter int MAG_W = 8
) (
  input  logic [1:0]       dir,
  input  logic [MAG_W-1:0] ctr,
  input  logic [MAG_W-1:0] lf,
  input  logic [MAG_W-1:0] rt,
  input  logic [MAG_W-1:0] up,
  input  logic [MAG_W-1:0] dn,
  input  logic [MAG_W-1:0] ul,
  input  logic [MAG_W-1:0] ur,
  input  logic [MAG_W-1:0] dl,
  input  logic [MAG_W-1:0] dr,
  output logic             keep
);
  logic [MAG_W-1:0] side_a, side_b;

  always_comb begin
    unique case (grad_dir_e'(dir))
      DIR_H:    begin side_a = lf; side_b = rt; end
      DIR_D45:  begin side_a = ur; side_b = dl; end
      DIR_V:    begin side_a = up; side_b = dn; end
      default:  begin side_a = ul; side_b = dr; end
    endcase
    keep = (ctr > side_a) && (ctr > side_b);
  end
endmodule

// File: rtl/nms_thin.sv
module nms_thin import nms_pkg::*; #(
  parameter int FRAME_W = 32,
  parameter int FRAME_H = 16,
  parameter int MAG_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [MAG_W-1:0] in_mag,
  input  logic [1:0]       in_dir,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eol,
  output logic [MAG_W-1:0] out_mag
);
  localparam int LINE_DEPTH = FRAME_W - 1;   // RAM delay is depth+1 = one line
  localparam int PACK_W     = MAG_W + 5;
  localparam int FILL_W     = $clog2(FRAME_W + 2);
  localparam logic [FILL_W-1:0] FILL_DONE = FILL_W'(FRAME_W + 1);

  // Bottom row of the window: current input and two older samples.
  logic [MAG_W-1:0] bot_d, bot_dl;
  // Middle row: line memory output, centre, left.
  logic [PACK_W-1:0] line_a_out, mid_c;
  logic [MAG_W-1:0]  mid_l;
  // Top row: line memory output, above, upper-left.
  logic [MAG_W-1:0] line_b_out, top_u, top_ul;

  logic [FILL_W-1:0] fill_q;
  logic              primed;

  nms_line_delay #(.DW(PACK_W), .DEPTH(LINE_DEPTH)) u_line_a (
    .clk (clk), .rst (rst),
    .din ({in_valid, in_sof, in_eol, in_dir, in_mag}),
    .dout(line_a_out)
  );

  nms_line_delay #(.DW(MAG_W), .DEPTH(LINE_DEPTH)) u_line_b (
    .clk (clk), .rst (rst),
    .din (line_a_out[MAG_W-1:0]),
    .dout(line_b_out)
  );

  always_ff @(posedge clk) begin
    bot_d  <= in_mag;
    bot_dl <= bot_d;
    mid_c  <= line_a_out;
    mid_l  <= mid_c[MAG_W-1:0];
    top_u  <= line_b_out;
    top_ul <= top_u;
  end

  // Line memories hold stale contents until one line has passed since reset.
  always_ff @(posedge clk) begin
    if (rst)                  fill_q <= '0;
    else if (fill_q != FILL_DONE) fill_q <= fill_q + 1'b1;
  end
  assign primed = (fill_q == FILL_DONE);

  logic             c_valid, c_sof, c_eol;
  logic [1:0]       c_dir;
  logic [MAG_W-1:0] c_mag;

  assign c_valid = mid_c[PACK_W-1] & primed;
  assign c_sof   = mid_c[PACK_W-2];
  assign c_eol   = mid_c[PACK_W-3];
  assign c_dir   = mid_c[MAG_W+1:MAG_W];
  assign c_mag   = mid_c[MAG_W-1:0];

  logic keep, border;

  nms_peak #(.MAG_W(MAG_W)) u_peak (
    .dir(c_dir), .ctr(c_mag),
    .lf (mid_l), .rt(line_a_out[MAG_W-1:0]),
    .up (top_u), .dn(bot_d),
    .ul (top_ul), .ur(line_b_out),
    .dl (bot_dl), .dr(in_mag),
    .keep(keep)
  );

  nms_raster_pos #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_pos (
    .clk(clk), .rst(rst), .valid(c_valid), .sof(c_sof), .border(border)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_mag   <= '0;
    end else begin
      out_valid <= c_valid;
      out_sof   <= c_valid & c_sof;
      out_eol   <= c_valid & c_eol;
      out_mag   <= (c_valid && keep && !border) ? c_mag : '0;
    end
  end

  // Direction pairing checked against the raw window taps.
  assert_keep_h_R3: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_dir == DIR_H && keep) |->
      (c_mag > mid_l && c_mag > line_a_out[MAG_W-1:0]));
  assert_keep_d45_R3: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_dir == DIR_D45 && keep) |-> (c_mag > line_b_out && c_mag > bot_dl));
  assert_keep_v_R3: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_dir == DIR_V && keep) |-> (c_mag > top_u && c_mag > bot_d));
  assert_keep_d135_R3: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_dir == DIR_D135 && keep) |-> (c_mag > top_ul && c_mag > in_mag));
  assert_tie_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_dir == DIR_V && (c_mag == top_u || c_mag == bot_d)) |=> (out_mag == '0));
  assert_border_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (c_valid && border) |=> (out_valid && out_mag == '0));
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_mag == '0 && !out_sof && !out_eol));
endmodule

// File: tb/nms_thin_test.sv
`timescale 1ns/1ps
module nms_thin_test;
  localparam int W   = 8;
  localparam int H   = 6;
  localparam int MW  = 8;
  localparam int LAT = W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [MW-1:0] in_mag = '0;
  logic [1:0] in_dir = '0;
  logic out_valid, out_sof, out_eol;
  logic [MW-1:0] out_mag;

  always #2 clk = ~clk;

  nms_thin #(.FRAME_W(W), .FRAME_H(H), .MAG_W(MW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_mag(in_mag), .in_dir(in_dir), .out_valid(out_valid), .out_sof(out_sof),
    .out_eol(out_eol), .out_mag(out_mag)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  int fm [H][W];
  int fd [H][W];
  int exp_m [int];
  int exp_s [int];
  int exp_e [int];
  string exp_r [int];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Per-clock comparison against the behavioural model.
  always @(negedge clk) begin
    if (running) begin
      if (exp_m.exists(cyc)) begin
        check(out_valid == 1'b1, "R2", "out_valid", int'(out_valid), 1);
        check(int'(out_mag) == exp_m[cyc], exp_r[cyc], "out_mag", int'(out_mag), exp_m[cyc]);
        check(int'(out_sof) == exp_s[cyc], "R7", "out_sof", int'(out_sof), exp_s[cyc]);
        check(int'(out_eol) == exp_e[cyc], "R2", "out_eol", int'(out_eol), exp_e[cyc]);
      end else begin
        check(out_valid == 1'b0, "R2", "spurious out_valid", int'(out_valid), 0);
        check(out_mag == '0 && !out_sof && !out_eol, "R6", "idle outputs",
              int'(out_mag), 0);
      end
    end
  end

  function automatic int ref_px(int r, int c, output string tag);
    int a, b, m;
    if (r == 0 || r == H-1 || c == 0 || c == W-1) begin
      tag = "R5";
      return 0;
    end
    m = fm[r][c];
    case (fd[r][c])
      0: begin a = fm[r][c-1];   b = fm[r][c+1];   end
      1: begin a = fm[r-1][c+1]; b = fm[r+1][c-1]; end
      2: begin a = fm[r-1][c];   b = fm[r+1][c];   end
      default: begin a = fm[r-1][c-1]; b = fm[r+1][c+1]; end
    endcase
    tag = (m == a || m == b) ? "R4" : "R3";
    return (m > a && m > b) ? m : 0;
  endfunction

  // mode 0: wide random; 1: low range ties; 2: flat; 3..6: fixed dir 0..3; 7: near max
  task automatic drive_frame(input int mode, input int gap);
    int base;
    string tag;
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        case (mode)
          0: begin fm[r][c] = $urandom_range(255); fd[r][c] = $urandom_range(3); end
          1: begin fm[r][c] = $urandom_range(2);   fd[r][c] = $urandom_range(3); end
          2: begin fm[r][c] = 100;                  fd[r][c] = $urandom_range(3); end
          7: begin fm[r][c] = 250 + $urandom_range(5); fd[r][c] = $urandom_range(3); end
          default: begin fm[r][c] = $urandom_range(9); fd[r][c] = mode - 3; end
        endcase
      end
    end
    base = cyc;
    for (int k = 0; k < W*H; k++) begin
      int r = k / W;
      int c = k % W;
      exp_m[base + k + LAT] = ref_px(r, c, tag);
      exp_r[base + k + LAT] = tag;
      exp_s[base + k + LAT] = (k == 0) ? 1 : 0;
      exp_e[base + k + LAT] = (c == W-1) ? 1 : 0;
    end
    for (int k = 0; k < W*H; k++) begin
      in_valid = 1'b1;
      in_sof   = (k == 0);
      in_eol   = ((k % W) == W-1);
      in_mag   = MW'(fm[k / W][k % W]);
      in_dir   = 2'(fd[k / W][k % W]);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eol   = 1'b0;
    in_mag   = '0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs quiet while in reset
    check(out_valid == 1'b0 && out_mag == '0, "R1", "outputs in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && !out_sof && !out_eol && out_mag == '0, "R1",
          "outputs after reset", int'(out_mag), 0);
    running = 1'b1;
    drive_frame(0, 3);       // R3 R4 R5 general
    drive_frame(1, 0);       // R4 ties, back to back (R7)
    drive_frame(2, 0);       // R4 flat plateau, back to back
    drive_frame(3, 5);       // R3 code 00
    drive_frame(4, 2);       // R3 code 01
    drive_frame(5, 0);       // R3 code 10
    drive_frame(6, 7);       // R3 code 11
    drive_frame(7, 1);       // R4 near-maximum magnitudes
    drive_frame(0, 0);
    drive_frame(1, LAT + 6);
    running = 1'b0;
    finish_run();
  end
endmodule